// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block turns a simple synchronous request port into the strobe sequence of an asynchronous 4M x 1 dynamic memory. A request carries a 22-bit cell address, a write flag and one data bit. The controller splits the address into an 11-bit row (upper half) and an 11-bit column (lower half) and sends both over one shared set of address pins. The row goes out ahead of the row strobe and the column goes out ahead of the column strobe. Writes are sequenced as early writes: the write enable and the data bit settle before the column strobe falls, so the column strobe latches the data. Reads sample the memory output in the last cycle of the column strobe. The sampled bit comes back on a one-cycle response pulse.

After an access the row stays open with the row strobe held low. A later request to the same row only strobes a new column, in any column order and with reads and writes in any mix. A request to another row first precharges by raising the row strobe, then opens the new row. A counter measures how long the row strobe has been low. Once it reaches a limit, the controller closes the row at the next access boundary. All strobe widths and delays are parameter counts of clock cycles.

The state machine has eight states:
- `ST_IDLE`: row closed, ready.
- `ST_ROW_HOLD`: row strobe low, row address held.
- `ST_COL_WAIT`: column address and write controls set up.
- `ST_CAS_LOW`: column strobe low.
- `ST_CAS_PRE`: column strobe precharge.
- `ST_PAGE_OPEN`: row open, ready.
- `ST_COL_SETUP`: column setup for a page hit.
- `ST_RAS_PRE`: row strobe precharge.

The transitions are:
- IDLE to ROW_HOLD on an accepted request.
- ROW_HOLD to COL_WAIT after `T_RAH` cycles.
- COL_WAIT to CAS_LOW once `T_RCD` cycles have passed since the row strobe fell.
- CAS_LOW to CAS_PRE after `T_CAS` cycles.
- CAS_PRE to PAGE_OPEN after `T_CP` cycles.
- PAGE_OPEN to COL_SETUP on an accepted same-row request.
- PAGE_OPEN to RAS_PRE on an accepted other-row request or on reaching the age limit.
- COL_SETUP to CAS_LOW after one cycle.
- RAS_PRE to ROW_HOLD after `T_RP` cycles when a request is pending, otherwise to IDLE.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Address bits [21:11] are the row and bits [10:0] are the column. The row is on `dram_addr` in the cycle the row strobe falls and for `T_RAH` cycles in total from that cycle. The column is on `dram_addr` one cycle before the column strobe falls and stays there while the column strobe is low.
- R3: When a row is opened, `dram_cas_n` falls exactly `T_RCD` cycles after `dram_ras_n` falls.
- R4: Every column strobe is low for exactly `T_CAS` cycles. `dram_cas_n` is never 0 while `dram_ras_n` is 1.
- R5: Between two column strobes in one open row, `dram_cas_n` stays high for at least `T_CP` cycles.
- R6: Once `dram_ras_n` rises, it stays high for at least `T_RP` cycles before it falls again.
- R7: A request accepted while its row is open is served by a column strobe alone, with no row strobe transition, for any column order and any mix of reads and writes.
- R8: A request to a row other than the open one closes the row, precharges, and opens the new row, which adds exactly one row strobe fall.
- R9: For a write, `dram_we_n` is 0 and `dram_din` equals the write bit from at least one cycle before the column strobe falls until it rises (early write). A write produces no `rsp_valid`.
- R10: For a read, `dram_we_n` stays 1. `dram_dout` is sampled in the last low cycle of the column strobe. `rsp_valid` pulses for one cycle in the next cycle with that bit on `rsp_rdata`, one pulse per read, in request order.
- R11: A request is accepted only on a cycle with `req_valid` and `req_ready` both 1. `req_ready` is 1 only in the idle and open-row states, so it is 0 whenever the column strobe is low.
- R12: Once the row strobe has been low for `T_RAS_MAX` cycles, no further access starts on that row and the row closes. No low period of `dram_ras_n` exceeds `T_RAS_MAX + T_CAS + T_CP + 2` cycles. This holds with requests pending and with none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_addr | input | 22 | Cell address, row in the upper half |
| req_we | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 1 | Write data bit |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 1 | Read data bit |
| dram_addr | output | 11 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | 1 | Data to the memory |
| dram_dout | input | 1 | Data from the memory |

## Verification
A stale or wrong open-row register causes a page hit on the wrong row. The column strobe then falls while the memory holds a row other than the request's row. This shows at the pins at that very column strobe fall, and as a wrong read bit in the response pulse a few cycles later. An off-by-one in the shared cycle timer changes a strobe width or the row-to-column delay within the first access after reset, so it is visible in the first strobe sequence. A broken age counter shows either as a row strobe held low past its bound or as a row that never reopens during a long same-row burst.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_HOLD,
        ST_COL_WAIT,
        ST_CAS_LOW,
        ST_CAS_PRE,
        ST_PAGE_OPEN,
        ST_COL_SETUP,
        ST_RAS_PRE
    } fpm_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_timer.sv
module fpm_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/fpm_row_track.sv
module fpm_row_track #(
    parameter int ROW_W     = 11,
    parameter int AGE_LIMIT = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set,
    input  logic             close,
    input  logic [ROW_W-1:0] row_in,
    input  logic [ROW_W-1:0] row_cmp,
    input  logic             ras_low,
    output logic             hit,
    output logic             aged
);
    localparam int AGE_W = $clog2(AGE_LIMIT + 1) + 1;
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(AGE_LIMIT);

    logic [ROW_W-1:0] open_row;
    logic             open_vld;
    logic [AGE_W-1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_row <= '0;
            open_vld <= 1'b0;
        end else if (open_set) begin
            open_row <= row_in;
            open_vld <= 1'b1;
        end else if (close) begin
            open_vld <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !ras_low) age <= '0;
        else if (age != AGE_MAX) age <= age + 1'b1;
    end

    assign hit  = open_vld && (row_cmp == open_row);
    assign aged = (age == AGE_MAX);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int COL_W     = 11,
    parameter int T_RAH     = 1,
    parameter int T_RCD     = 3,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 2,
    parameter int T_RP      = 3,
    parameter int T_RAS_MAX = 40,
    localparam int ADDR_W   = ROW_W + COL_W,
    localparam int PIN_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic              req_wdata,
    output logic              rsp_valid,
    output logic              rsp_rdata,
    output logic [PIN_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_din,
    input  logic              dram_dout
);
    localparam int T_LONG = max2(max2(T_RAH, T_RCD), max2(max2(T_CAS, T_CP), T_RP));
    localparam int CNT_W  = $clog2(T_LONG + 1) + 1;
    localparam logic [CNT_W-1:0] L_RAH = CNT_W'(T_RAH - 1);
    localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD - T_RAH - 1);
    localparam logic [CNT_W-1:0] L_CAS = CNT_W'(T_CAS - 1);
    localparam logic [CNT_W-1:0] L_CP  = CNT_W'(T_CP - 1);
    localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP - 1);

    fpm_state_e        state, nxt;
    logic [ADDR_W-1:0] q_addr;
    logic              q_we, q_wdata, pend;
    logic              accept, tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;
    logic              open_set, close, row_hit, row_aged, ras_low;
    logic [ROW_W-1:0]  set_row;

    fpm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    fpm_row_track #(.ROW_W(ROW_W), .AGE_LIMIT(T_RAS_MAX)) u_rows (
        .clk(clk), .rst_n(rst_n), .open_set(open_set), .close(close),
        .row_in(set_row), .row_cmp(req_addr[ADDR_W-1:COL_W]),
        .ras_low(ras_low), .hit(row_hit), .aged(row_aged)
    );

    assign accept  = req_valid && req_ready;
    assign set_row = (state == ST_IDLE) ? req_addr[ADDR_W-1:COL_W] : q_addr[ADDR_W-1:COL_W];

    // next-state and timer loads
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        open_set = 1'b0;
        close    = 1'b0;
        unique case (state)
            ST_IDLE: if (accept) begin
                nxt = ST_ROW_HOLD; tmr_load = 1'b1; tmr_val = L_RAH; open_set = 1'b1;
            end
            ST_ROW_HOLD: if (tmr_done) begin
                nxt = ST_COL_WAIT; tmr_load = 1'b1; tmr_val = L_RCD;
            end
            ST_COL_WAIT: if (tmr_done) begin
                nxt = ST_CAS_LOW; tmr_load = 1'b1; tmr_val = L_CAS;
            end
            ST_CAS_LOW: if (tmr_done) begin
                nxt = ST_CAS_PRE; tmr_load = 1'b1; tmr_val = L_CP;
            end
            ST_CAS_PRE: if (tmr_done) nxt = ST_PAGE_OPEN;
            ST_PAGE_OPEN: begin
                if (row_aged || (accept && !row_hit)) begin
                    nxt = ST_RAS_PRE; tmr_load = 1'b1; tmr_val = L_RP; close = 1'b1;
                end else if (accept) begin
                    nxt = ST_COL_SETUP;
                end
            end
            ST_COL_SETUP: begin
                nxt = ST_CAS_LOW; tmr_load = 1'b1; tmr_val = L_CAS;
            end
            ST_RAS_PRE: if (tmr_done) begin
                if (pend) begin
                    nxt = ST_ROW_HOLD; tmr_load = 1'b1; tmr_val = L_RAH; open_set = 1'b1;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_we    <= 1'b0;
            q_wdata <= 1'b0;
            pend    <= 1'b0;
        end else begin
            if (accept) begin
                q_addr  <= req_addr;
                q_we    <= req_we;
                q_wdata <= req_wdata;
            end
            if (state == ST_PAGE_OPEN && accept && !row_hit && !row_aged) pend <= 1'b1;
            else if (state == ST_RAS_PRE && tmr_done)                     pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= 1'b0;
        end else begin
            rsp_valid <= (state == ST_CAS_LOW) && tmr_done && !q_we;
            if ((state == ST_CAS_LOW) && tmr_done && !q_we) rsp_rdata <= dram_dout;
        end
    end

    // pin outputs
    always_comb begin
        logic col_phase;
        col_phase  = (state == ST_COL_WAIT) || (state == ST_COL_SETUP) || (state == ST_CAS_LOW);
        ras_low    = (state != ST_IDLE) && (state != ST_RAS_PRE);
        dram_ras_n = !ras_low;
        dram_cas_n = (state != ST_CAS_LOW);
        dram_we_n  = !(col_phase && q_we);
        dram_din   = col_phase && q_we && q_wdata;
        req_ready  = (state == ST_IDLE) || ((state == ST_PAGE_OPEN) && !row_aged);
        if (state == ST_IDLE || state == ST_ROW_HOLD || state == ST_RAS_PRE)
            dram_addr = PIN_W'(q_addr[ADDR_W-1:COL_W]);
        else
            dram_addr = PIN_W'(q_addr[COL_W-1:0]);
    end
endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk #(
    parameter int PIN_W     = 11,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 2,
    parameter int T_RP      = 3,
    parameter int T_RAS_MAX = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [PIN_W-1:0] dram_addr,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic             dram_we_n,
    input logic             dram_din
);
    localparam int LO_LIM = T_RAS_MAX + T_CAS + T_CP + 1;
    localparam int CW     = $clog2(LO_LIM + T_RP + 2) + 1;

    logic [CW-1:0] lo_cnt, hi_cnt;
    logic          opened;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
            opened <= 1'b0;
        end else begin
            lo_cnt <= dram_ras_n ? '0 : lo_cnt + 1'b1;
            if (!dram_ras_n)                 hi_cnt <= '0;
            else if (hi_cnt != CW'(T_RP))    hi_cnt <= hi_cnt + 1'b1;
            if (!dram_ras_n) opened <= 1'b1;
        end
    end

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);                                           // R4
    AST_BUSY_DURING_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !req_ready);                                            // R11
    AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $stable(dram_we_n) && $stable(dram_din));        // R9
    AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_we_n) && $stable(dram_din)); // R9
    AST_COL_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $stable(dram_addr));                              // R2
    AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));           // R2
    AST_RSP_AT_CAS_END: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(dram_cas_n));                                       // R10
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                              // R10
    AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (opened && $fell(dram_ras_n)) |-> (hi_cnt >= CW'(T_RP)));              // R6
    AST_RAS_LOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (lo_cnt <= CW'(LO_LIM)));                               // R12
endmodule

bind fpm_dram_ctrl fpm_dram_chk #(
    .PIN_W(PIN_W), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_din(dram_din)
);

// File: tb/sim_fpm_dram_ctrl.sv
module sim_fpm_dram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int T_RAH = 1, T_RCD = 3, T_CAS = 2, T_CP = 2, T_RP = 3, T_RAS_MAX = 40;
    localparam int LOW_BOUND = T_RAS_MAX + T_CAS + T_CP + 2;

    typedef struct { logic [21:0] a; bit we; bit d; } req_t;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0, req_wdata = 1'b0;
    logic [21:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_rdata;
    logic [10:0] dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_din;
    logic        dout_r = 1'b0;

    int checks = 0, fails = 0;
    req_t pq[$];
    bit   rexp[$];
    bit   shadow [int];
    bit   mem [int];
    int   nopen = 0, exp_open = 0, model_row = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpm_dram_ctrl #(.T_RAH(T_RAH), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
                    .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_din(dram_din), .dram_dout(dout_r)
    );

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic finish_tb();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // behavioural memory device and per-cycle protocol checks
    bit   prev_ras = 1, prev_cas = 1, prev_we = 1, ever_open = 0, cur_first = 0, cur_rd = 0;
    int   since_ras = 0, cas_lo = 0, cas_hi = 100, ras_hi = 100, ras_lo = 0;
    logic [10:0] cur_row = '0;
    bit   last_val = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit ras_fall, ras_rise, cas_fall, cas_rise;
            ras_fall = prev_ras && !dram_ras_n;
            ras_rise = !prev_ras && dram_ras_n;
            cas_fall = prev_cas && !dram_cas_n;
            cas_rise = !prev_cas && dram_cas_n;

            if (!dram_cas_n && dram_ras_n) chk(0, "R4", "cas low under ras high", 0, 1);
            if (!dram_cas_n) chk(req_ready == 0, "R11", "ready during cas low", req_ready, 0);

            if (ras_fall) begin
                nopen++;
                if (ever_open) chk(ras_hi >= T_RP, "R6", "ras precharge width", ras_hi, T_RP);
                ever_open = 1;
                cur_row = dram_addr;
                since_ras = 0;
                ras_lo = 1;
                cur_first = 1;
                if (pq.size() > 0)
                    chk(dram_addr == pq[0].a[21:11], "R2", "row at ras fall", dram_addr, pq[0].a[21:11]);
                else
                    chk(0, "R11", "ras fall without request", 1, 0);
            end else if (!dram_ras_n) begin
                since_ras++;
                ras_lo++;
                if (since_ras < T_RAH) chk(dram_addr == cur_row, "R2", "row hold", dram_addr, cur_row);
            end
            if (!dram_ras_n) chk(ras_lo <= LOW_BOUND, "R12", "ras low length", ras_lo, LOW_BOUND);
            if (ras_rise) ras_hi = 1; else if (dram_ras_n) ras_hi++;

            if (cas_fall) begin
                if (cur_first) chk(since_ras == T_RCD, "R3", "ras to cas delay", since_ras, T_RCD);
                else           chk(cas_hi >= T_CP, "R5", "cas precharge width", cas_hi, T_CP);
                cur_first = 0;
                cas_lo = 1;
                if (pq.size() == 0) begin
                    chk(0, "R11", "cas fall without request", 1, 0);
                end else begin
                    req_t r;
                    int   key;
                    r = pq.pop_front();
                    key = {cur_row, dram_addr};
                    chk(cur_row == r.a[21:11], "R7", "open row matches request", cur_row, r.a[21:11]);
                    chk(dram_addr == r.a[10:0], "R2", "column at cas fall", dram_addr, r.a[10:0]);
                    cur_rd = !r.we;
                    if (r.we) begin
                        chk(prev_we == 0 && dram_we_n == 0, "R9", "we low before cas", prev_we, 0);
                        chk(dram_din == r.d, "R9", "write data", dram_din, r.d);
                        mem[key] = dram_din;
                    end else begin
                        chk(dram_we_n == 1, "R10", "we high for read", dram_we_n, 1);
                        last_val = mem.exists(key) ? mem[key] : 1'b0;
                    end
                end
            end else if (!dram_cas_n) begin
                cas_lo++;
                if (cur_rd) chk(dram_we_n == 1, "R10", "we high during read", dram_we_n, 1);
            end
            if (cas_rise) begin
                chk(cas_lo == T_CAS, "R4", "cas low width", cas_lo, T_CAS);
                cas_hi = 1;
            end else if (dram_cas_n) cas_hi++;

            dout_r = (!dram_cas_n && cur_rd) ? last_val : ~last_val;

            if (rsp_valid) begin
                if (rexp.size() == 0) chk(0, "R9", "response without read", 1, 0);
                else begin
                    bit e;
                    e = rexp.pop_front();
                    chk(rsp_rdata == e, "R10", "read data", rsp_rdata, e);
                end
            end

            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
            prev_we  = dram_we_n;
        end
    end

    task automatic do_req(input logic [21:0] a, input bit we, input bit d);
        req_t r;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        r.a = a; r.we = we; r.d = d;
        pq.push_back(r);
        if (we) shadow[int'(a)] = d;
        else    rexp.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 1'b0);
        if (int'(a[21:11]) != model_row) exp_open++;
        model_row = int'(a[21:11]);
        @(posedge clk);
    endtask

    task automatic drain();
        @(negedge clk);
        req_valid = 1'b0;
        while (pq.size() > 0 || rexp.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic settle();
        drain();
        repeat (LOW_BOUND + T_RP + 4) @(negedge clk);
        model_row = -1;
    endtask

    function automatic logic [21:0] mk(input int row, input int col);
        return {11'(row), 11'(col)};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "R11", "watchdog expired", 0, 1);
        finish_tb();
    end

    initial begin
        int base_o, base_e;
        repeat (3) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && req_ready && !rsp_valid, "R1", "pins in reset", 0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && req_ready && !rsp_valid, "R1", "idle after reset", 0, 1);

        // R7: page hits, mixed order and direction
        base_o = nopen; base_e = exp_open;
        do_req(mk(5, 10), 1, 1);
        do_req(mk(5, 10), 0, 0);
        do_req(mk(5, 3), 1, 1);
        do_req(mk(5, 2047), 0, 0);
        do_req(mk(5, 3), 0, 0);
        drain();
        chk(nopen - base_o == exp_open - base_e, "R7", "row opens for page burst", nopen - base_o, exp_open - base_e);
        settle();

        // R8: row misses with corner addresses
        base_o = nopen; base_e = exp_open;
        do_req(mk(9, 0), 0, 0);
        do_req(mk(2047, 2047), 1, 1);
        do_req(mk(0, 0), 1, 1);
        do_req(mk(2047, 2047), 0, 0);
        do_req(mk(5, 10), 0, 0);
        do_req(mk(0, 0), 0, 0);
        drain();
        chk(nopen - base_o == exp_open - base_e, "R8", "row opens for misses", nopen - base_o, exp_open - base_e);
        settle();

        // mixed traffic over a few rows and columns
        for (int i = 0; i < 60; i++) begin
            int row, col;
            row = (i % 7 < 4) ? 5 : ((i % 3 == 0) ? 9 : 2047);
            col = int'($urandom_range(0, 7)) * 291;
            do_req(mk(row, col), ($urandom_range(0, 1) == 1), ($urandom_range(0, 1) == 1));
        end
        drain();

        // R12: long same-row burst forces the row closed and reopened
        settle();
        base_o = nopen;
        for (int i = 0; i < 16; i++) do_req(mk(77, i), 0, 0);
        drain();
        chk(nopen - base_o >= 2, "R12", "forced reopen in burst", nopen - base_o, 2);

        // R12: idle open row closes by age
        do_req(mk(77, 1), 1, 1);
        drain();
        repeat (LOW_BOUND + 2) @(negedge clk);
        chk(dram_ras_n == 1 && req_ready == 1, "R12", "idle row closed", dram_ras_n, 1);

        finish_tb();
    end
endmodule